// File: doc/BRIEF.md
# Synchronous Burst SRAM with Wrapping Address Counter

This block is a clocked single-port word memory with a four-beat burst engine in front of it. Each word is 18 bits: two 8-bit byte lanes, each with its own parity bit. A burst opens when either of two start strobes is seen at a clock edge. One strobe serves a processor and always performs a read. The other serves a cache controller and may read or write. The starting address is captured in a register. A 2-bit beat counter then forms the low two address bits for the following beats, so every burst stays inside its aligned group of four words. The counter steps only in cycles where the advance input is high. A mode input picks the beat order: linear, where the low bits are the start bits plus the beat number modulo 4, or interleaved, where they are the start bits XOR the beat number.

Writes are synchronous. Data, the global write input and the per-lane enables are all sampled on the clock edge, and the array is updated at that same edge. Reads return the addressed word on the output port right after the edge that performs the access. Chip selects are sampled at burst start. The output enable gates the data drive combinationally and does not wait for a clock. A sleep input freezes every access and keeps both the array and the burst state. The depth is set by the address-width parameter, so a small array can be simulated.

Top module: `sync_burst_sram`

## Requirements
- R1: When a start strobe is accepted with both selects high and sleep low, the full address is captured and the word at that address is accessed at that edge. For a read, the word is on dataOut with dataDrive high after the edge, provided outEn is high.
- R2: procStart is accepted only while selPrimary is high. It takes priority over ctrlStart and always reads, whatever the write inputs are. While selPrimary is low, procStart has no effect, and the open burst continues as if no strobe had been given.
- R3: In an open burst with no start strobe, the beat counter advances by one only when advance is high. Otherwise the current address is accessed again.
- R4: With orderIlv low, beat n addresses the start address with its low two bits replaced by (start low bits + n) mod 4. The upper bits never change during the burst.
- R5: With orderIlv high, beat n uses low bits equal to start low bits XOR n. The counter wraps after four beats.
- R6: In a controller-started or continuing burst cycle, globalWr high writes all 18 bits of dataIn to the current address. dataDrive is low after a write cycle.
- R7: With globalWr low and byteWrEn high, lane i (bits 8i+7..8i, plus parity bit 16+i) is written only when laneWr[i] is high. Other bits keep their value. With byteWrEn low and globalWr low, the cycle is a read.
- R8: A start strobe with the chip selects not both high ends the open burst. Output drive stops, and later advance cycles access nothing until a new burst starts.
- R9: dataDrive equals outEn AND (last access was a read) AND NOT sleep, and changes with outEn without a clock edge. dataOut is zero whenever dataDrive is low.
- R10: While sleep is high, no access, write or counter step happens, the burst state and array contents are kept, and the output is not driven.
- R11: After reset no burst is open and dataDrive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of control state |
| addrIn | input | ADDR_W | Burst start address |
| procStart | input | 1 | Processor start strobe (read only) |
| ctrlStart | input | 1 | Controller start strobe (read or write) |
| advance | input | 1 | Step the burst counter this cycle |
| globalWr | input | 1 | Write all 18 bits |
| byteWrEn | input | 1 | Enable per-lane writes |
| laneWr | input | 2 | Per-lane write enables |
| selPrimary | input | 1 | Primary chip select, sampled on clock |
| selAux | input | 1 | Secondary chip select, sampled on clock |
| orderIlv | input | 1 | 1 = interleaved beat order, 0 = linear |
| outEn | input | 1 | Output enable, acts combinationally |
| sleep | input | 1 | Low-power hold: all accesses ignored |
| dataIn | input | 18 | Write data: bits 15..0 data, 16 and 17 lane parity |
| dataOut | output | 18 | Read data, zero when not driven |
| dataDrive | output | 1 | High when dataOut drives the shared bus |

## Verification
The bench walks bursts from start addresses whose low bits are not zero, in both orders. A design that carried the counter into the upper address bits, or that used the linear order in place of XOR, would read a word from the wrong group or in the wrong sequence. It gives a processor strobe together with an active global write, and a processor strobe while the primary select is low. A design that wrote on the processor strobe would corrupt the word. A design that failed to ignore the strobe would restart the burst at the new address. Single-lane writes show whether a parity bit follows its lane. A write attempt during sleep, followed by a read of the same burst, shows whether sleep really freezes the array and the counter. Dropping outEn in the middle of a cycle shows whether the drive is gated without a clock.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic doRead;
    logic doWrite;
    logic dropValid;
  } access_t;
endpackage

// File: rtl/burst_ctrl.sv
`timescale 1ns/1ps
module burst_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStart,
  input  logic              ctrlStart,
  input  logic              advance,
  input  logic              globalWr,
  input  logic              byteWrEn,
  input  logic [LANES-1:0]  laneWr,
  input  logic              selPrimary,
  input  logic              selAux,
  input  logic              orderIlv,
  input  logic              sleep,
  output access_t           acc,
  output logic [ADDR_W-1:0] accAddr
);
  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beatCnt, nextCnt, lowBits;
  logic              burstOpen;
  logic              procTake, ctrlTake, anyStart, selected, wrReq;

  assign selected = selPrimary & selAux;
  assign procTake = procStart & selPrimary;
  assign ctrlTake = ~procTake & ctrlStart;
  assign anyStart = procTake | ctrlTake;
  assign wrReq    = globalWr | (byteWrEn & (|laneWr));
  assign nextCnt  = advance ? beatCnt + 1'b1 : beatCnt;

  always_comb begin
    if (orderIlv) lowBits = baseAddr[BEAT_W-1:0] ^ nextCnt;
    else          lowBits = baseAddr[BEAT_W-1:0] + nextCnt;
  end

  always_comb begin
    acc     = '0;
    accAddr = {baseAddr[ADDR_W-1:BEAT_W], lowBits};
    if (!sleep) begin
      if (anyStart && selected) begin
        accAddr     = addrIn;
        acc.doWrite = ctrlTake & wrReq;
        acc.doRead  = ~(ctrlTake & wrReq);
      end else if (anyStart) begin
        acc.dropValid = 1'b1;
      end else if (burstOpen) begin
        acc.doWrite = wrReq;
        acc.doRead  = ~wrReq;
      end else begin
        acc.dropValid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr  <= '0;
      beatCnt   <= '0;
      burstOpen <= 1'b0;
    end else if (!sleep) begin
      if (anyStart && selected) begin
        baseAddr  <= addrIn;
        beatCnt   <= '0;
        burstOpen <= 1'b1;
      end else if (anyStart) begin
        burstOpen <= 1'b0;
      end else if (burstOpen) begin
        beatCnt <= nextCnt;
      end
    end
  end

  a_r1_start_loads: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && anyStart && selected) |=> (burstOpen && beatCnt == '0 && baseAddr == $past(addrIn)));
  a_r3_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !anyStart && burstOpen && !advance) |=> (beatCnt == $past(beatCnt)));
  a_r3_step_beat: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !anyStart && burstOpen && advance) |=> (beatCnt == BEAT_W'($past(beatCnt) + 1'b1)));
  a_r4_stay_in_group: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !anyStart && burstOpen) |-> (accAddr[ADDR_W-1:BEAT_W] == baseAddr[ADDR_W-1:BEAT_W]));
  a_r8_deselect_closes: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && anyStart && !selected) |=> !burstOpen);
  a_r10_sleep_frozen: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(beatCnt) && $stable(baseAddr) && $stable(burstOpen)));
  a_r10_sleep_no_access: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (acc == '0));
endmodule

// File: rtl/sram_datapath.sv
`timescale 1ns/1ps
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int WORD_W = LANES * (BYTE_W + 1),
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  access_t           acc,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              globalWr,
  input  logic              byteWrEn,
  input  logic [LANES-1:0]  laneWr,
  input  logic              outEn,
  input  logic              sleep,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataDrive
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] wrMask, rdData;
  logic [LANES-1:0]  laneSel;
  logic              rdValid;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneSel[g] = globalWr | (byteWrEn & laneWr[g]);
    assign wrMask[g*BYTE_W +: BYTE_W] = {BYTE_W{laneSel[g]}};
    assign wrMask[LANES*BYTE_W + g]   = laneSel[g];
  end

  always_ff @(posedge clk) begin
    if (acc.doWrite) mem[accAddr] <= (mem[accAddr] & ~wrMask) | (dataIn & wrMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else if (acc.doWrite || acc.dropValid) begin
      rdValid <= 1'b0;
    end else if (acc.doRead) begin
      rdData  <= mem[accAddr];
      rdValid <= 1'b1;
    end
  end

  assign dataDrive = outEn & rdValid & ~sleep;
  assign dataOut   = dataDrive ? rdData : '0;

  a_r2_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(acc.doRead && acc.doWrite));
  a_r6_full_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (acc.doWrite && globalWr) |=> (mem[$past(accAddr)] == $past(dataIn)));
  a_r6_write_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    acc.doWrite |=> !rdValid);
  a_r8_drop_stops_drive: assert property (@(posedge clk) disable iff (!rstN)
    acc.dropValid |=> !dataDrive);
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int WORD_W = LANES * (BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStart,
  input  logic              ctrlStart,
  input  logic              advance,
  input  logic              globalWr,
  input  logic              byteWrEn,
  input  logic [LANES-1:0]  laneWr,
  input  logic              selPrimary,
  input  logic              selAux,
  input  logic              orderIlv,
  input  logic              outEn,
  input  logic              sleep,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataDrive
);
  access_t           acc;
  logic [ADDR_W-1:0] accAddr;

  burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStart(procStart),
    .ctrlStart(ctrlStart), .advance(advance), .globalWr(globalWr),
    .byteWrEn(byteWrEn), .laneWr(laneWr), .selPrimary(selPrimary),
    .selAux(selAux), .orderIlv(orderIlv), .sleep(sleep),
    .acc(acc), .accAddr(accAddr)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) i_dp (
    .clk(clk), .rstN(rstN), .acc(acc), .accAddr(accAddr), .dataIn(dataIn),
    .globalWr(globalWr), .byteWrEn(byteWrEn), .laneWr(laneWr),
    .outEn(outEn), .sleep(sleep), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  a_r9_oe_gates_drive: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (!dataDrive && dataOut == '0));
  a_r11_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> !dataDrive);
endmodule

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  addrIn;
  logic        procStart, ctrlStart, advance, globalWr, byteWrEn;
  logic [1:0]  laneWr;
  logic        selPrimary, selAux, orderIlv, outEn, sleep;
  logic [17:0] dataIn, dataOut;
  logic        dataDrive;

  int    checks = 0;
  int    errors = 0;
  bit    modelOn = 0;
  bit    finished = 0;
  string curReq = "R1";

  logic [17:0] refMem [64];
  logic [17:0] refData;
  bit          refValid, refActive;
  int          refBase, refCnt;

  always #10 clk = ~clk;

  sync_burst_sram i_sync_burst_sram (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStart(procStart),
    .ctrlStart(ctrlStart), .advance(advance), .globalWr(globalWr),
    .byteWrEn(byteWrEn), .laneWr(laneWr), .selPrimary(selPrimary),
    .selAux(selAux), .orderIlv(orderIlv), .outEn(outEn), .sleep(sleep),
    .dataIn(dataIn), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  function automatic logic [17:0] pat(int a);
    return 18'((a * 179) ^ 18'h2A5A);
  endfunction

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic refAccess(int a, bit wr);
    if (wr) begin
      for (int l = 0; l < 2; l++) begin
        if (globalWr || (byteWrEn && laneWr[l])) begin
          refMem[a][l*8 +: 8] = dataIn[l*8 +: 8];
          refMem[a][16 + l]   = dataIn[16 + l];
        end
      end
      refValid = 0;
    end else begin
      refData  = refMem[a];
      refValid = 1;
    end
  endtask

  // Behavioural reference: beat order per R4/R5, strobes per R1/R2/R8, sleep per R10
  always @(posedge clk) begin
    bit pS, cS, sel, wr;
    int low;
    if (!rstN) begin
      refActive = 0; refValid = 0; refCnt = 0;
    end else if (!sleep) begin
      pS  = procStart && selPrimary;
      cS  = !pS && ctrlStart;
      sel = selPrimary && selAux;
      wr  = globalWr || (byteWrEn && laneWr != 2'b00);
      if (pS || cS) begin
        if (sel) begin
          refBase = int'(addrIn); refCnt = 0; refActive = 1;
          refAccess(refBase, cS && wr);
        end else begin
          refActive = 0; refValid = 0;
        end
      end else if (refActive) begin
        if (advance) refCnt = (refCnt + 1) % 4;
        low = orderIlv ? ((refBase % 4) ^ refCnt) : (((refBase % 4) + refCnt) % 4);
        refAccess(refBase - (refBase % 4) + low, wr);
      end else begin
        refValid = 0;
      end
    end
  end

  // Every-cycle comparison, R9 output gating included
  always @(negedge clk) begin
    bit expDrive;
    if (rstN && modelOn) begin
      expDrive = outEn && refValid && !sleep;
      chk(curReq, {17'b0, dataDrive}, {17'b0, expDrive});
      chk(curReq, dataOut, expDrive ? refData : 18'h0);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic idle();
    procStart = 0; ctrlStart = 0; advance = 0; globalWr = 0; byteWrEn = 0;
    laneWr = 2'b00; selPrimary = 1; selAux = 1; outEn = 1; sleep = 0;
  endtask

  task automatic burstRead(int start, bit ilv, int e[5], string req);
    idle(); orderIlv = ilv; curReq = req;
    ctrlStart = 1; addrIn = 6'(start);
    tick();
    ctrlStart = 0;
    chk(req, dataOut, pat(e[0]));
    advance = 1;
    for (int i = 1; i < 5; i++) begin
      tick();
      chk(req, dataOut, pat(e[i]));
    end
    advance = 0;
  endtask

  initial begin
    idle(); orderIlv = 0; addrIn = '0; dataIn = '0; rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk("R11", {17'b0, dataDrive}, 18'h0);
    rstN = 1; modelOn = 1;
    tick();
    chk("R11", {17'b0, dataDrive}, 18'h0);

    // R6: fill the whole array with full-word writes in linear bursts
    curReq = "R6";
    for (int b = 0; b < 64; b += 4) begin
      idle(); globalWr = 1; ctrlStart = 1; addrIn = 6'(b); dataIn = pat(b);
      tick();
      ctrlStart = 0; advance = 1;
      for (int k = 1; k < 4; k++) begin
        dataIn = pat(b + k);
        tick();
        chk("R6", {17'b0, dataDrive}, 18'h0);
      end
    end

    // R4 linear and R5 interleaved orders, with wrap to the start beat
    burstRead(6, 0, '{6, 7, 4, 5, 6}, "R4");
    burstRead(5, 0, '{5, 6, 7, 4, 5}, "R4");
    burstRead(6, 1, '{6, 7, 4, 5, 6}, "R5");
    burstRead(5, 1, '{5, 4, 7, 6, 5}, "R5");
    burstRead(43, 1, '{43, 42, 41, 40, 43}, "R5");

    // R3: no step without advance
    idle(); curReq = "R3"; orderIlv = 0; ctrlStart = 1; addrIn = 6'd9;
    tick(); ctrlStart = 0;
    tick(); chk("R3", dataOut, pat(9));
    tick(); chk("R3", dataOut, pat(9));
    advance = 1; tick(); chk("R3", dataOut, pat(10));
    advance = 0; tick(); chk("R3", dataOut, pat(10));

    // R7: single-lane writes carry their parity bit only
    idle(); curReq = "R7"; ctrlStart = 1; addrIn = 6'd12; byteWrEn = 1;
    laneWr = 2'b01; dataIn = 18'h3FFFF;
    tick();
    idle(); ctrlStart = 1; addrIn = 6'd13; byteWrEn = 1; laneWr = 2'b10; dataIn = 18'h0;
    tick();
    idle(); ctrlStart = 1; addrIn = 6'd12; tick();
    chk("R7", dataOut, pat(12) | 18'h100FF);
    ctrlStart = 0; advance = 1; tick();
    chk("R7", dataOut, pat(13) & ~18'h2FF00);

    // R2: processor strobe reads despite global write, and is ignored when primary select low
    idle(); curReq = "R2"; procStart = 1; globalWr = 1; addrIn = 6'd20; dataIn = 18'h0;
    tick();
    chk("R2", dataOut, pat(20));
    idle(); procStart = 1; selPrimary = 0; addrIn = 6'd40;
    tick();
    chk("R2", dataOut, pat(20));
    idle(); tick();
    chk("R2", dataOut, pat(20));

    // R8: deselect through a start strobe closes the burst
    idle(); curReq = "R8"; ctrlStart = 1; selAux = 0; addrIn = 6'd24;
    tick();
    chk("R8", {17'b0, dataDrive}, 18'h0);
    idle(); advance = 1; tick();
    chk("R8", {17'b0, dataDrive}, 18'h0);

    // R9: output enable acts with no clock edge
    idle(); curReq = "R9"; ctrlStart = 1; addrIn = 6'd3;
    tick(); ctrlStart = 0;
    outEn = 0; #1;
    chk("R9", {17'b0, dataDrive}, 18'h0);
    chk("R9", dataOut, 18'h0);
    outEn = 1; #1;
    chk("R9", {17'b0, dataDrive}, 18'h1);
    chk("R9", dataOut, pat(3));

    // R10: sleep ignores a write and keeps the open burst
    idle(); curReq = "R10"; ctrlStart = 1; addrIn = 6'd30;
    tick();
    idle(); sleep = 1; ctrlStart = 1; globalWr = 1; addrIn = 6'd30; dataIn = 18'h0;
    tick();
    chk("R10", {17'b0, dataDrive}, 18'h0);
    advance = 1; tick();
    idle(); tick();
    chk("R10", dataOut, pat(30));

    // R1: long mixed traffic against the reference model
    curReq = "R1";
    for (int n = 0; n < 4000; n++) begin
      procStart  = ($urandom % 8) == 0;
      ctrlStart  = ($urandom % 6) == 0;
      advance    = $urandom % 2;
      globalWr   = ($urandom % 5) == 0;
      byteWrEn   = ($urandom % 4) == 0;
      laneWr     = 2'($urandom);
      selPrimary = ($urandom % 10) != 0;
      selAux     = ($urandom % 10) != 0;
      orderIlv   = $urandom % 2;
      outEn      = ($urandom % 8) != 0;
      sleep      = ($urandom % 16) == 0;
      addrIn     = 6'($urandom);
      dataIn     = 18'($urandom);
      tick();
    end

    idle(); tick();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule